// File: doc/BRIEF.md
# ADC Result Buffer and Interrupt Controller

This block sits between the conversion engine of an analog-to-digital converter and a processor. Each finished conversion arrives as a 12-bit result tagged with the channel it came from. The block stores it in a 16-entry result buffer and raises a completion interrupt after a programmable number of results. The processor reads the buffer through an indexed read port.

There are three ways to store results. Linear mode fills slots in order and restarts at slot 0 at every interrupt. Split mode alternates between the lower and upper halves at each interrupt, and a status bit tells software which half is being filled. Channel-indexed mode puts each result in the slot numbered by its channel. The block also supplies the channel for the next sample. That channel is a fixed selection A, an alternation between selections A and B, or, when scanning, a walk through an enable mask that stands in place of selection A.

The mode bits are loaded from the configuration inputs on a one-cycle write strobe. That strobe, or dropping the enable, clears the sample counter, write pointer, A/B toggle and scan position.

Top module: `adc_result_buf`

## Requirements
- R1: With interrupt-rate field k (5 bits), `irq_pulse` goes high after the (k+1)th accepted result since the count last restarted: k=0 gives a pulse for every result, k=31 gives a pulse for every 32nd.
- R2: In linear mode (`cfg_chan_idx`=0, `cfg_split`=0), the first result after a restart goes to slot 0 and each later one to the next slot. The slot after an interrupting result is slot 0 again.
- R3: In split mode (`cfg_split`=1, `cfg_chan_idx`=0), filling starts at slot 0 and moves to slot 8 after the first interrupt, back to slot 0 after the next, and so on. `fill_upper` is 1 while the upper half (slots 8 to 15) is being filled and 0 otherwise. It changes only with an interrupt, a mode write or disable.
- R4: In channel-indexed mode (`cfg_chan_idx`=1), each result is written to the slot equal to `res_chan`, the split setting has no effect, and `fill_upper` stays 0.
- R5: With `cfg_alt`=1, `next_ch` alternates between selection A and `sel_b_ch` on successive accepted results, starting with A. With `cfg_alt`=0, selection A is always used.
- R6: With `cfg_scan`=1, selection A is the lowest set bit of `scan_mask` at or above the scan position, wrapping past 15 to 0. Each accepted result that used selection A moves the position one past the chosen channel. An all-zero mask gives channel 0.
- R7: `irq_pulse` lasts one cycle per interrupting result and is visible in the cycle after that result's clock edge, together with its written data. `irq_flag` sets with it and stays set until `irq_clr` is 1. A pulse on the same edge as a clear wins.
- R8: While `enable` is 0, results are ignored: no slot is written and no pulse is raised. Disabling, or a `cfg_we` strobe, restarts the count, pointer, toggle and scan position.
- R9: After reset, every slot reads 0, `irq_pulse`, `irq_flag` and `fill_upper` are 0, and all mode bits are 0.
- R10: `rd_data` shows, combinationally, the contents of slot `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter on; 0 ignores results and restarts state |
| cfg_we | input | 1 | Strobe that loads the mode bits below and restarts state |
| cfg_rate | input | 5 | Interrupt after every (value+1) results |
| cfg_chan_idx | input | 1 | Channel-indexed storage |
| cfg_split | input | 1 | Split half-buffer storage |
| cfg_alt | input | 1 | Alternate selections A and B |
| cfg_scan | input | 1 | Selection A walks the scan mask |
| sel_a_ch | input | 4 | Fixed channel for selection A |
| sel_b_ch | input | 4 | Channel for selection B |
| scan_mask | input | 16 | Channels enabled for scanning |
| res_valid | input | 1 | A result is presented this cycle |
| res_data | input | 12 | Conversion result |
| res_chan | input | 4 | Channel the result came from |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| rd_idx | input | 4 | Read slot index |
| next_ch | output | 4 | Channel to convert next |
| irq_pulse | output | 1 | One-cycle completion interrupt |
| irq_flag | output | 1 | Sticky interrupt flag |
| fill_upper | output | 1 | Upper half being filled (split mode) |
| rd_data | output | 12 | Contents of slot rd_idx |

## Verification
Split mode is driven with a table of twelve results at rate 3. It shows whether the write slot, the half switch and the status bit all change on the interrupting result and not one result early or late. Linear mode at rate 4 shows the restart to slot 0, and rates 0 and 31 cover the two ends of the count. Channel-indexed results with split set show that the slot follows the channel tag and that the split setting has no effect. A sparse scan mask shows the skipping and the wrap. A/B alternation is run with scanning both off and on, which shows whether the scan position moves only on A samples.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
    localparam int RATE_W = 5;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              chan_idx;
        logic              split;
        logic              alt;
        logic              scan;
    } mode_t;
endpackage

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
    parameter int NCH = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic [CHW-1:0] start,
    output logic [CHW-1:0] ch,
    output logic           hit
);
    logic [CHW-1:0] idx;

    // Walk offsets from highest to lowest so the nearest set bit wins.
    always_comb begin
        ch  = '0;
        hit = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            idx = start + CHW'(i);
            if (mask[idx]) begin
                ch  = idx;
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_result_mem.sv
module adc_result_mem #(
    parameter int DEPTH = 16,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_buf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cfg_we,
    input  mode_t         cfg_in,
    input  logic          irq_clr,
    input  logic          res_valid,
    input  logic [AW-1:0] res_chan,
    input  logic [AW-1:0] sel_a,
    input  logic [AW-1:0] sel_b,
    input  logic [AW-1:0] scan_ch,
    input  logic          scan_hit,
    output logic [AW-1:0] scan_start,
    output logic [AW-1:0] next_ch,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          irq_pulse,
    output logic          irq_flag,
    output logic          fill_upper
);
    typedef struct packed {
        mode_t             mode;
        logic [RATE_W-1:0] cnt;
        logic [AW-1:0]     wptr;
        logic              half;
        logic              ab;
        logic [AW-1:0]     sptr;
        logic              pulse;
        logic              flag;
    } state_t;

    state_t st_d, st_q;
    logic   accept;
    logic   use_b;
    logic   terminal;
    logic   split_on;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        use_b      = st_q.mode.alt & st_q.ab;
        terminal   = (st_q.cnt == st_q.mode.rate);
        split_on   = st_q.mode.split & ~st_q.mode.chan_idx;
        accept     = res_valid & enable & ~cfg_we;

        if (cfg_we) begin
            st_d.mode = cfg_in;
        end

        if (!enable || cfg_we) begin
            st_d.cnt  = '0;
            st_d.wptr = '0;
            st_d.half = 1'b0;
            st_d.ab   = 1'b0;
            st_d.sptr = '0;
        end else if (res_valid) begin
            st_d.ab = st_q.mode.alt ? ~st_q.ab : 1'b0;
            if (!use_b && st_q.mode.scan && scan_hit) begin
                st_d.sptr = scan_ch + AW'(1);
            end
            if (terminal) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                if (split_on) begin
                    st_d.half = ~st_q.half;
                    st_d.wptr = st_q.half ? '0 : AW'(HALF);
                end else begin
                    st_d.wptr = '0;
                end
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
                st_d.wptr = st_q.wptr + 1'b1;
            end
        end

        if (st_d.pulse) begin
            st_d.flag = 1'b1;
        end else if (irq_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_start = st_q.sptr;
    assign next_ch    = use_b ? sel_b : (st_q.mode.scan ? scan_ch : sel_a);
    assign wr_en      = accept;
    assign wr_addr    = st_q.mode.chan_idx ? res_chan : st_q.wptr;
    assign irq_pulse  = st_q.pulse;
    assign irq_flag   = st_q.flag;
    assign fill_upper = split_on & st_q.half;
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf
    import adc_buf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cfg_we,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic              cfg_chan_idx,
    input  logic              cfg_split,
    input  logic              cfg_alt,
    input  logic              cfg_scan,
    input  logic [AW-1:0]     sel_a_ch,
    input  logic [AW-1:0]     sel_b_ch,
    input  logic [DEPTH-1:0]  scan_mask,
    input  logic              res_valid,
    input  logic [DW-1:0]     res_data,
    input  logic [AW-1:0]     res_chan,
    input  logic              irq_clr,
    input  logic [AW-1:0]     rd_idx,
    output logic [AW-1:0]     next_ch,
    output logic              irq_pulse,
    output logic              irq_flag,
    output logic              fill_upper,
    output logic [DW-1:0]     rd_data
);
    mode_t         cfg_in;
    logic [AW-1:0] scan_start;
    logic [AW-1:0] scan_ch;
    logic          scan_hit;
    logic          wr_en;
    logic [AW-1:0] wr_addr;

    assign cfg_in = '{rate: cfg_rate, chan_idx: cfg_chan_idx, split: cfg_split,
                      alt: cfg_alt, scan: cfg_scan};

    adc_scan_pick #(.NCH(DEPTH)) u_pick (
        .mask  (scan_mask),
        .start (scan_start),
        .ch    (scan_ch),
        .hit   (scan_hit)
    );

    adc_seq_ctrl #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_we     (cfg_we),
        .cfg_in     (cfg_in),
        .irq_clr    (irq_clr),
        .res_valid  (res_valid),
        .res_chan   (res_chan),
        .sel_a      (sel_a_ch),
        .sel_b      (sel_b_ch),
        .scan_ch    (scan_ch),
        .scan_hit   (scan_hit),
        .scan_start (scan_start),
        .next_ch    (next_ch),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .irq_pulse  (irq_pulse),
        .irq_flag   (irq_flag),
        .fill_upper (fill_upper)
    );

    adc_result_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (res_data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );
endmodule

// File: rtl/adc_result_buf_chk.sv
module adc_result_buf_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic res_valid,
    input logic cfg_we,
    input logic irq_clr,
    input logic irq_pulse,
    input logic irq_flag,
    input logic fill_upper
);
    // R1: an interrupt only follows an accepted result
    a_r1_pulse_has_result: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(res_valid && enable && !cfg_we));

    // R7: the sticky flag is set whenever a pulse is out
    a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_flag);

    // R7: a clear with no competing pulse empties the flag
    a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_clr) && !irq_pulse) |-> !irq_flag);

    // R8: a disabled converter raises no interrupt
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_pulse);

    // R3: the fill-status bit moves only with an interrupt, mode write or disable
    a_r3_status_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fill_upper) |-> (irq_pulse || $past(cfg_we) || !$past(enable)));
endmodule

bind adc_result_buf adc_result_buf_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .res_valid  (res_valid),
    .cfg_we     (cfg_we),
    .irq_clr    (irq_clr),
    .irq_pulse  (irq_pulse),
    .irq_flag   (irq_flag),
    .fill_upper (fill_upper)
);

// File: tb/adc_result_buf_tb_top.sv
module adc_result_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        cfg_we;
    logic [4:0]  cfg_rate;
    logic        cfg_chan_idx, cfg_split, cfg_alt, cfg_scan;
    logic [3:0]  sel_a_ch, sel_b_ch;
    logic [15:0] scan_mask;
    logic        res_valid;
    logic [11:0] res_data;
    logic [3:0]  res_chan;
    logic        irq_clr;
    logic [3:0]  rd_idx;
    logic [3:0]  next_ch;
    logic        irq_pulse, irq_flag, fill_upper;
    logic [11:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    adc_result_buf dut_i (.*);

    // {exp_irq, exp_upper, slot[3:0], data[11:0]}: split mode, rate 3
    localparam logic [17:0] VEC [12] = '{
        {1'b0, 1'b0, 4'd0,  12'hA00}, {1'b0, 1'b0, 4'd1,  12'hA01},
        {1'b0, 1'b0, 4'd2,  12'hA02}, {1'b1, 1'b1, 4'd3,  12'hA03},
        {1'b0, 1'b1, 4'd8,  12'hA04}, {1'b0, 1'b1, 4'd9,  12'hA05},
        {1'b0, 1'b1, 4'd10, 12'hA06}, {1'b1, 1'b0, 4'd11, 12'hA07},
        {1'b0, 1'b0, 4'd0,  12'hA08}, {1'b0, 1'b0, 4'd1,  12'hA09},
        {1'b0, 1'b0, 4'd2,  12'hA0A}, {1'b1, 1'b1, 4'd3,  12'hA0B}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [4:0] rate, input logic ci, input logic sp,
                           input logic al, input logic sc);
        cfg_rate = rate; cfg_chan_idx = ci; cfg_split = sp; cfg_alt = al; cfg_scan = sc;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [11:0] d, input logic [3:0] ch);
        res_data = d; res_chan = ch; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic peek(input logic [3:0] idx, output logic [11:0] v);
        rd_idx = idx;
        #1;
        v = rd_data;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        int npulse;
        rst_n = 1'b0; enable = 1'b0; cfg_we = 1'b0; cfg_rate = '0;
        cfg_chan_idx = 0; cfg_split = 0; cfg_alt = 0; cfg_scan = 0;
        sel_a_ch = 4'd6; sel_b_ch = 4'd9; scan_mask = '0;
        res_valid = 0; res_data = '0; res_chan = '0; irq_clr = 0; rd_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        npulse = 0;
        for (int i = 0; i < 16; i++) begin
            peek(4'(i), v);
            if (v != 0) npulse++;
        end
        chk("R9 slots zero", npulse, 0);
        chk("R9 outputs", {irq_pulse, irq_flag, fill_upper}, 3'b000);
        chk("R9 next_ch is sel A", next_ch, 4'd6);

        // R8: disabled results ignored
        push(12'hFFF, 4'd0);
        peek(4'd0, v);
        chk("R8 no write when disabled", v, 12'h000);
        chk("R8 no pulse when disabled", irq_pulse, 1'b0);
        enable = 1'b1;

        // R3/R10: table-driven split mode
        set_cfg(5'd3, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++) begin
            push(VEC[i][11:0], 4'd0);
            chk($sformatf("R3 irq step %0d", i), irq_pulse, VEC[i][17]);
            chk($sformatf("R3 fill_upper step %0d", i), fill_upper, VEC[i][16]);
            peek(VEC[i][15:12], v);
            chk($sformatf("R10 slot data step %0d", i), v, VEC[i][11:0]);
        end

        // R2: linear mode, rate 4, wrap to slot 0 after interrupt
        set_cfg(5'd4, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) push(12'h200 + 12'(i), 4'd0);
        chk("R2 pulse on 5th", irq_pulse, 1'b1);
        chk("R2 fill_upper 0 outside split", fill_upper, 1'b0);
        push(12'h2FF, 4'd0);
        peek(4'd0, v);
        chk("R2 restart at slot 0", v, 12'h2FF);
        peek(4'd4, v);
        chk("R2 fifth in slot 4", v, 12'h204);

        // R1: rate 0 pulses every result
        set_cfg(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        push(12'h011, 4'd0);
        chk("R1 rate0 first", irq_pulse, 1'b1);
        push(12'h022, 4'd0);
        chk("R1 rate0 second", irq_pulse, 1'b1);
        peek(4'd0, v);
        chk("R2 rate0 stays slot 0", v, 12'h022);

        // R1: rate 31 pulses on the 32nd result only
        set_cfg(5'd31, 1'b0, 1'b0, 1'b0, 1'b0);
        npulse = 0;
        for (int i = 0; i < 31; i++) begin
            push(12'h300, 4'd0);
            if (irq_pulse) npulse++;
        end
        chk("R1 rate31 none before 32", npulse, 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        push(12'h300, 4'd0);
        chk("R1 rate31 pulse at 32", irq_pulse, 1'b1);

        // R7: pulse lasts one cycle, flag sticky until cleared
        chk("R7 flag set", irq_flag, 1'b1);
        @(negedge clk);
        chk("R7 pulse single cycle", irq_pulse, 1'b0);
        chk("R7 flag sticky", irq_flag, 1'b1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R7 flag cleared", irq_flag, 1'b0);

        // R7: pulse beats a simultaneous clear
        set_cfg(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        irq_clr = 1'b1;
        push(12'h001, 4'd0);
        irq_clr = 1'b0;
        chk("R7 set wins over clear", irq_flag, 1'b1);

        // R4: channel-indexed, split setting ignored
        set_cfg(5'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        push(12'h555, 4'd5);
        push(12'hCCC, 4'd12);
        chk("R4 fill_upper stays 0", fill_upper, 1'b0);
        peek(4'd5, v);
        chk("R4 slot by channel 5", v, 12'h555);
        peek(4'd12, v);
        chk("R4 slot by channel 12", v, 12'hCCC);

        // R8: cfg_we restarts the count
        set_cfg(5'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        push(12'h001, 4'd0);
        set_cfg(5'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        push(12'h002, 4'd0);
        chk("R8 cfg write restarts count", irq_pulse, 1'b0);
        push(12'h003, 4'd0);
        chk("R8 count after restart", irq_pulse, 1'b1);

        // R8: disable restarts the count
        set_cfg(5'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        push(12'h001, 4'd0);
        push(12'h002, 4'd0);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        push(12'h003, 4'd0);
        chk("R8 disable restarts count", irq_pulse, 1'b0);

        // R5: alternate A/B
        set_cfg(5'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 first is A", next_ch, 4'd6);
        push(12'h0, 4'd6);
        chk("R5 second is B", next_ch, 4'd9);
        push(12'h0, 4'd9);
        chk("R5 third is A", next_ch, 4'd6);
        set_cfg(5'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        push(12'h0, 4'd6);
        chk("R5 alt off stays A", next_ch, 4'd6);

        // R6: scan mask bits 2, 13, 15
        scan_mask = 16'hA004;
        set_cfg(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 scan first 2", next_ch, 4'd2);
        push(12'h0, 4'd2);
        chk("R6 scan skip to 13", next_ch, 4'd13);
        push(12'h0, 4'd13);
        chk("R6 scan 15", next_ch, 4'd15);
        push(12'h0, 4'd15);
        chk("R6 scan wraps to 2", next_ch, 4'd2);

        // R6/R5: scan advances only on A samples
        set_cfg(5'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        push(12'h0, 4'd2);
        chk("R6 B sample after scan", next_ch, 4'd9);
        push(12'h0, 4'd9);
        chk("R6 scan resumes at 13", next_ch, 4'd13);

        scan_mask = 16'h0000;
        set_cfg(5'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R6 empty mask gives 0", next_ch, 4'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule